// File: doc/BRIEF.md
# Channel-Routed Interprocessor Event Unit

This block lets one processor signal another over a set of numbered event channels. Software on the sending side writes a send-task register. The unit then pulses every outgoing channel that the task's own routing mask selects. On the receiving side, each receive event has its own mask of incoming channels. The event latches when any channel in that mask pulses. It stays latched until software clears it. A latched event can raise the interrupt output if its enable bit is set.

Every task also has a subscribe hook, and every event has a publish hook. Each hook holds a channel number on an external event-channel fabric and an enable flag. A subscribed fabric pulse fires the task without software. A newly latched event emits a one-cycle pulse on its published fabric channel. A small array of 32-bit words is also provided, which both processors can share for message data. All register accesses are single-cycle: a write takes effect at the clock edge, and read data is combinational from the address.

Top module: `xproc_event_unit`

## Requirements
- R1: The channel count is a parameter that may be 8 or 16. There is one send task and one receive event per channel, and every routing mask is as wide as the channel count.
- R2: Writing a word with bit 0 set to task register n (byte offset 0x000 + 4n) drives `chan_out` equal to send mask n for exactly the one cycle after the write edge. Writing bit 0 as 0, or firing a task whose mask is zero, produces no pulse.
- R3: A write to send mask n (0x510 + 4n) or receive mask n (0x590 + 4n) replaces the whole previous mask. A read returns the stored mask.
- R4: Receive event n latches at the edge on which any `chan_in` bit selected by receive mask n is high. Reading event register n (0x100 + 4n) returns 1 in bit 0 once it has latched.
- R5: A latched event stays set until a write with bit 0 equal to 0 reaches its event register. Writing a 1 there has no effect. An incoming pulse at the same edge as a clear leaves the event set.
- R6: A write to 0x300 sets, and a write to 0x304 clears, each interrupt enable bit whose write-data bit is 1. Reading either address returns the current enable mask.
- R7: Address 0x308 reads, at bit n, event n set AND enable n. `irq` is the OR of those bits.
- R8: The hook registers sit 0x80 above their task or event: subscribe n at 0x080 + 4n, publish n at 0x180 + 4n. Bit 31 is the enable flag and bits 7:0 are the fabric channel. A read returns exactly these fields, and writing 0 disables the hook.
- R9: An enabled subscribe hook fires its task at the edge where its fabric channel on `fab_in` is high. A software fire and a subscribed fire of the same task at the same edge give a single one-cycle pulse.
- R10: An enabled publish hook drives its fabric channel on `fab_out` high for one cycle, in the cycle where its event first reads set. An event that was already set emits nothing, and neither does a disabled hook.
- R11: Memory word k at 0x610 + 4k is readable and writable for k below the word count. For k from the word count up to 31, reads return 0 and writes change nothing.
- R12: After reset, all masks, hooks, events, enables, memory words and outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 12 | Byte address of the register access |
| reg_we | input | 1 | Write strobe for the current cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| chan_in | input | NUM_CH | Incoming channel pulses |
| chan_out | output | NUM_CH | Outgoing channel pulses |
| fab_in | input | FAB_CH | Event-fabric channels, for subscriptions |
| fab_out | output | FAB_CH | Event-fabric channels, driven by publications |
| irq | output | 1 | Interrupt request, OR of pending bits |

## Verification
The bench builds the unit with NUM_CH = 16, NUM_MEM = 4 and FAB_CH = 16. With 16 channels, task 15 and the upper mask bits can be exercised, which covers the wider variant of R1. With only four memory words inside a 32-word window, index 4 is an in-window address that must be ignored. With sixteen fabric channels, a subscription and a publication can use different channel numbers, so the two hook directions do not mask each other. A scoreboard queues every expected `chan_out` and `fab_out` pulse. Any pulse that arrives unexpected, or lasts a second cycle, is reported as a failure.

// File: rtl/evtu_pkg.sv
package evtu_pkg;
   localparam int unsigned ADDR_W = 12;
   localparam int unsigned MEM_WIN = 32;

   // Register map (byte offsets); hooks sit 0x80 above their task/event.
   localparam logic [ADDR_W-1:0] BASE_TASK   = 12'h000;
   localparam logic [ADDR_W-1:0] BASE_SUB    = 12'h080;
   localparam logic [ADDR_W-1:0] BASE_EVT    = 12'h100;
   localparam logic [ADDR_W-1:0] BASE_PUB    = 12'h180;
   localparam logic [ADDR_W-1:0] OFF_INTSET  = 12'h300;
   localparam logic [ADDR_W-1:0] OFF_INTCLR  = 12'h304;
   localparam logic [ADDR_W-1:0] OFF_INTPEND = 12'h308;
   localparam logic [ADDR_W-1:0] BASE_SCFG   = 12'h510;
   localparam logic [ADDR_W-1:0] BASE_RCFG   = 12'h590;
   localparam logic [ADDR_W-1:0] BASE_MEM    = 12'h610;

   typedef struct packed {
      logic       en;
      logic [7:0] ch;
   } hook_cfg_t;

   function automatic hook_cfg_t hook_decode(input logic [31:0] w);
      hook_cfg_t h;
      h.en = w[31];
      h.ch = w[7:0];
      return h;
   endfunction

   function automatic logic [31:0] hook_encode(input hook_cfg_t h);
      return {h.en, 23'd0, h.ch};
   endfunction

   // True when a is a word-aligned address among the n words from base.
   function automatic logic in_win(input logic [ADDR_W-1:0] a,
                                   input logic [ADDR_W-1:0] base,
                                   input int unsigned n);
      int unsigned ai;
      int unsigned bi;
      ai = int'(a);
      bi = int'(base);
      return (a[1:0] == 2'b00) && (ai >= bi) && (ai < bi + 4 * n);
   endfunction

   function automatic logic [ADDR_W-3:0] word_off(input logic [ADDR_W-1:0] a,
                                                  input logic [ADDR_W-1:0] base);
      logic [ADDR_W-1:0] d;
      d = a - base;
      return d[ADDR_W-1:2];
   endfunction
endpackage

// File: rtl/evtu_hook.sv
module evtu_hook
   import evtu_pkg::*;
#(
   parameter int unsigned FAB_CH = 16,
   parameter bit          DRIVE  = 1'b0
) (
   input  hook_cfg_t          cfg,
   input  logic [FAB_CH-1:0]  fab_in,
   input  logic               fire,
   output logic               hit,
   output logic [FAB_CH-1:0]  fab_drv
);
   logic [FAB_CH-1:0] sel;

   for (genvar i = 0; i < FAB_CH; i++) begin : g_sel
      assign sel[i] = cfg.en && (cfg.ch == 8'(i));
   end

   if (DRIVE) begin : g_drive
      logic unused_fab_in;
      assign unused_fab_in = ^fab_in;
      assign fab_drv = fire ? sel : '0;
      assign hit     = 1'b0;
   end else begin : g_listen
      logic unused_fire;
      assign unused_fire = fire;
      assign hit     = |(sel & fab_in);
      assign fab_drv = '0;
   end
endmodule

// File: rtl/evtu_send_path.sv
module evtu_send_path
   import evtu_pkg::*;
#(
   parameter int unsigned NUM_CH = 8,
   parameter int unsigned FAB_CH = 16
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_CH-1:0]              sw_fire,
   input  logic [NUM_CH-1:0]              cfg_wr,
   input  logic [NUM_CH-1:0]              sub_wr,
   input  logic [NUM_CH-1:0]              cfg_data,
   input  hook_cfg_t                      hook_data,
   input  logic [FAB_CH-1:0]              fab_in,
   output logic [NUM_CH-1:0]              chan_out,
   output logic [NUM_CH-1:0][NUM_CH-1:0]  scfg,
   output hook_cfg_t [NUM_CH-1:0]         sub_cfg
);
   logic [NUM_CH-1:0] sub_hit;
   logic [NUM_CH-1:0] fire;
   logic [NUM_CH-1:0] out_nxt;

   for (genvar n = 0; n < NUM_CH; n++) begin : g_task
      logic [FAB_CH-1:0] drv_unused;
      evtu_hook #(.FAB_CH(FAB_CH), .DRIVE(1'b0)) u_sub (
         .cfg     (sub_cfg[n]),
         .fab_in  (fab_in),
         .fire    (1'b0),
         .hit     (sub_hit[n]),
         .fab_drv (drv_unused)
      );
      assign fire[n] = sw_fire[n] | sub_hit[n];

      AST_TASK_FANOUT: assert property (@(posedge clk) disable iff (!rst_n)
         fire[n] |=> ((chan_out & $past(scfg[n])) == $past(scfg[n]))) // R2
         else $error("task fanout missing");
      AST_MASK_REPLACE: assert property (@(posedge clk) disable iff (!rst_n)
         cfg_wr[n] |=> (scfg[n] == $past(cfg_data))) // R3
         else $error("send mask not replaced");
   end

   always_comb begin
      out_nxt = '0;
      for (int n = 0; n < NUM_CH; n++) begin
         if (fire[n]) out_nxt = out_nxt | scfg[n];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scfg     <= '0;
         sub_cfg  <= '0;
         chan_out <= '0;
      end else begin
         for (int n = 0; n < NUM_CH; n++) begin
            if (cfg_wr[n]) scfg[n]    <= cfg_data;
            if (sub_wr[n]) sub_cfg[n] <= hook_data;
         end
         chan_out <= out_nxt;
      end
   end

   AST_SEND_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (fire == '0) |=> (chan_out == '0)) // R2
      else $error("pulse without a fired task");
endmodule

// File: rtl/evtu_recv_path.sv
module evtu_recv_path
   import evtu_pkg::*;
#(
   parameter int unsigned NUM_CH = 8,
   parameter int unsigned FAB_CH = 16
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_CH-1:0]              chan_in,
   input  logic [NUM_CH-1:0]              rcfg_wr,
   input  logic [NUM_CH-1:0]              pub_wr,
   input  logic [NUM_CH-1:0]              evt_clr,
   input  logic [NUM_CH-1:0]              cfg_data,
   input  hook_cfg_t                      hook_data,
   output logic [NUM_CH-1:0]              evt,
   output logic [NUM_CH-1:0][NUM_CH-1:0]  rcfg,
   output hook_cfg_t [NUM_CH-1:0]         pub_cfg,
   output logic [FAB_CH-1:0]              fab_out
);
   logic [NUM_CH-1:0]              catch_now;
   logic [NUM_CH-1:0]              rise;
   logic [NUM_CH-1:0][FAB_CH-1:0]  drv;
   logic [FAB_CH-1:0]              fab_nxt;

   for (genvar n = 0; n < NUM_CH; n++) begin : g_evt
      logic hit_unused;
      assign catch_now[n] = |(chan_in & rcfg[n]);
      assign rise[n]      = catch_now[n] & ~evt[n];
      evtu_hook #(.FAB_CH(FAB_CH), .DRIVE(1'b1)) u_pub (
         .cfg     (pub_cfg[n]),
         .fab_in  ('0),
         .fire    (rise[n]),
         .hit     (hit_unused),
         .fab_drv (drv[n])
      );

      AST_EVT_CATCH: assert property (@(posedge clk) disable iff (!rst_n)
         catch_now[n] |=> evt[n]) // R4
         else $error("event missed a pulse");
      AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (evt[n] && !evt_clr[n]) |=> evt[n]) // R5
         else $error("event dropped without clear");
   end

   always_comb begin
      fab_nxt = '0;
      for (int n = 0; n < NUM_CH; n++) fab_nxt = fab_nxt | drv[n];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt     <= '0;
         rcfg    <= '0;
         pub_cfg <= '0;
         fab_out <= '0;
      end else begin
         for (int n = 0; n < NUM_CH; n++) begin
            if (rcfg_wr[n]) rcfg[n]    <= cfg_data;
            if (pub_wr[n])  pub_cfg[n] <= hook_data;
         end
         // a pulse at the clearing edge wins over the clear
         evt     <= catch_now | (evt & ~evt_clr);
         fab_out <= fab_nxt;
      end
   end

   AST_PUB_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (fab_out != '0) |-> (|(evt & ~$past(evt)))) // R10
      else $error("publish pulse without a new event");
endmodule

// File: rtl/evtu_irq_ctrl.sv
module evtu_irq_ctrl #(
   parameter int unsigned NUM_CH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_wr,
   input  logic              clr_wr,
   input  logic [NUM_CH-1:0] mask,
   input  logic [NUM_CH-1:0] evt,
   output logic [NUM_CH-1:0] inten,
   output logic [NUM_CH-1:0] pend,
   output logic              irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      inten <= '0;
      else if (set_wr) inten <= inten | mask;
      else if (clr_wr) inten <= inten & ~mask;
   end

   assign pend = evt & inten;
   assign irq  = |pend;

   AST_INTEN_SET: assert property (@(posedge clk) disable iff (!rst_n)
      set_wr |=> ((inten & $past(mask)) == $past(mask))) // R6
      else $error("enable set lost");
   AST_INTEN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      clr_wr |=> ((inten & $past(mask)) == '0)) // R6
      else $error("enable clear lost");
   AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ((inten != '0) && (evt != '0))) // R7
      else $error("irq without enabled event");
endmodule

// File: rtl/evtu_shared_mem.sv
module evtu_shared_mem #(
   parameter int unsigned NUM_MEM = 4,
   parameter int unsigned IDX_W   = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [IDX_W-1:0] idx,
   input  logic [31:0]      wdata,
   output logic [31:0]      rdata
);
   localparam int unsigned AW = (NUM_MEM > 1) ? $clog2(NUM_MEM) : 1;

   logic [31:0] cells [NUM_MEM];
   logic        in_range;

   assign in_range = int'(idx) < NUM_MEM;
   assign rdata    = in_range ? cells[idx[AW-1:0]] : 32'd0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < NUM_MEM; k++) cells[k] <= '0;
      end else if (wr && in_range) begin
         cells[idx[AW-1:0]] <= wdata;
      end
   end

   AST_MEM_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && in_range) |=> (cells[$past(idx[AW-1:0])] == $past(wdata))) // R11
      else $error("memory write lost");
endmodule

// File: rtl/xproc_event_unit.sv
module xproc_event_unit
   import evtu_pkg::*;
#(
   parameter int unsigned NUM_CH  = 8,
   parameter int unsigned NUM_MEM = 4,
   parameter int unsigned FAB_CH  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [11:0]       reg_addr,
   input  logic              reg_we,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic [NUM_CH-1:0] chan_in,
   output logic [NUM_CH-1:0] chan_out,
   input  logic [FAB_CH-1:0] fab_in,
   output logic [FAB_CH-1:0] fab_out,
   output logic              irq
);
   localparam int unsigned CH_W  = $clog2(NUM_CH);
   localparam int unsigned MEM_W = $clog2(MEM_WIN);

   if (!(NUM_CH == 8 || NUM_CH == 16)) begin : g_bad_ch
      $error("NUM_CH must be 8 or 16");
   end
   if (NUM_MEM < 1 || NUM_MEM > MEM_WIN) begin : g_bad_mem
      $error("NUM_MEM out of range 1..32");
   end
   if (FAB_CH < 1 || FAB_CH > 256) begin : g_bad_fab
      $error("FAB_CH out of range 1..256");
   end

   // ---- address decode ----
   logic hit_task, hit_sub, hit_evt, hit_pub, hit_scfg, hit_rcfg, hit_mem;
   logic hit_iset, hit_iclr, hit_ipend;
   logic [CH_W-1:0]  idx_task, idx_sub, idx_evt, idx_pub, idx_scfg, idx_rcfg;
   logic [MEM_W-1:0] idx_mem;

   assign hit_task  = in_win(reg_addr, BASE_TASK, NUM_CH);
   assign hit_sub   = in_win(reg_addr, BASE_SUB,  NUM_CH);
   assign hit_evt   = in_win(reg_addr, BASE_EVT,  NUM_CH);
   assign hit_pub   = in_win(reg_addr, BASE_PUB,  NUM_CH);
   assign hit_scfg  = in_win(reg_addr, BASE_SCFG, NUM_CH);
   assign hit_rcfg  = in_win(reg_addr, BASE_RCFG, NUM_CH);
   assign hit_mem   = in_win(reg_addr, BASE_MEM,  MEM_WIN);
   assign hit_iset  = (reg_addr == OFF_INTSET);
   assign hit_iclr  = (reg_addr == OFF_INTCLR);
   assign hit_ipend = (reg_addr == OFF_INTPEND);

   assign idx_task = CH_W'(word_off(reg_addr, BASE_TASK));
   assign idx_sub  = CH_W'(word_off(reg_addr, BASE_SUB));
   assign idx_evt  = CH_W'(word_off(reg_addr, BASE_EVT));
   assign idx_pub  = CH_W'(word_off(reg_addr, BASE_PUB));
   assign idx_scfg = CH_W'(word_off(reg_addr, BASE_SCFG));
   assign idx_rcfg = CH_W'(word_off(reg_addr, BASE_RCFG));
   assign idx_mem  = MEM_W'(word_off(reg_addr, BASE_MEM));

   // ---- per-channel write strobes ----
   logic [NUM_CH-1:0] sw_fire, scfg_wr, sub_wr, rcfg_wr, pub_wr, evt_clr;

   for (genvar n = 0; n < NUM_CH; n++) begin : g_strobe
      assign sw_fire[n] = reg_we && hit_task && (idx_task == CH_W'(n)) && reg_wdata[0];
      assign sub_wr[n]  = reg_we && hit_sub  && (idx_sub  == CH_W'(n));
      assign evt_clr[n] = reg_we && hit_evt  && (idx_evt  == CH_W'(n)) && !reg_wdata[0];
      assign pub_wr[n]  = reg_we && hit_pub  && (idx_pub  == CH_W'(n));
      assign scfg_wr[n] = reg_we && hit_scfg && (idx_scfg == CH_W'(n));
      assign rcfg_wr[n] = reg_we && hit_rcfg && (idx_rcfg == CH_W'(n));
   end

   hook_cfg_t         hook_data;
   logic [NUM_CH-1:0] mask_data;
   assign hook_data = hook_decode(reg_wdata);
   assign mask_data = reg_wdata[NUM_CH-1:0];

   // ---- datapaths ----
   logic [NUM_CH-1:0][NUM_CH-1:0] scfg, rcfg;
   hook_cfg_t [NUM_CH-1:0]        sub_cfg, pub_cfg;
   logic [NUM_CH-1:0]             evt, inten, pend;
   logic [31:0]                   mem_rdata;

   evtu_send_path #(.NUM_CH(NUM_CH), .FAB_CH(FAB_CH)) u_send (
      .clk       (clk),
      .rst_n     (rst_n),
      .sw_fire   (sw_fire),
      .cfg_wr    (scfg_wr),
      .sub_wr    (sub_wr),
      .cfg_data  (mask_data),
      .hook_data (hook_data),
      .fab_in    (fab_in),
      .chan_out  (chan_out),
      .scfg      (scfg),
      .sub_cfg   (sub_cfg)
   );

   evtu_recv_path #(.NUM_CH(NUM_CH), .FAB_CH(FAB_CH)) u_recv (
      .clk       (clk),
      .rst_n     (rst_n),
      .chan_in   (chan_in),
      .rcfg_wr   (rcfg_wr),
      .pub_wr    (pub_wr),
      .evt_clr   (evt_clr),
      .cfg_data  (mask_data),
      .hook_data (hook_data),
      .evt       (evt),
      .rcfg      (rcfg),
      .pub_cfg   (pub_cfg),
      .fab_out   (fab_out)
   );

   evtu_irq_ctrl #(.NUM_CH(NUM_CH)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_wr (reg_we && hit_iset),
      .clr_wr (reg_we && hit_iclr),
      .mask   (mask_data),
      .evt    (evt),
      .inten  (inten),
      .pend   (pend),
      .irq    (irq)
   );

   evtu_shared_mem #(.NUM_MEM(NUM_MEM), .IDX_W(MEM_W)) u_mem (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (reg_we && hit_mem),
      .idx   (idx_mem),
      .wdata (reg_wdata),
      .rdata (mem_rdata)
   );

   // ---- read mux; task registers read as zero ----
   always_comb begin
      reg_rdata = '0;
      if (hit_evt)                reg_rdata = 32'(evt[idx_evt]);
      else if (hit_sub)           reg_rdata = hook_encode(sub_cfg[idx_sub]);
      else if (hit_pub)           reg_rdata = hook_encode(pub_cfg[idx_pub]);
      else if (hit_iset || hit_iclr) reg_rdata = 32'(inten);
      else if (hit_ipend)         reg_rdata = 32'(pend);
      else if (hit_scfg)          reg_rdata = 32'(scfg[idx_scfg]);
      else if (hit_rcfg)          reg_rdata = 32'(rcfg[idx_rcfg]);
      else if (hit_mem)           reg_rdata = mem_rdata;
   end

   AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      ((evt_clr != '0) && ((chan_in & ~chan_in) == '0) &&
       ((evt_clr & evt) != '0) && (|(evt_clr & ~evt)) == 1'b0 &&
       (rcfg[idx_evt] & chan_in) == '0) |=> !evt[$past(idx_evt)]) // R5
      else $error("event clear ignored");
endmodule

// File: tb/xproc_event_unit_tb_top.sv
`timescale 1ns/1ps
module xproc_event_unit_tb_top;
   localparam int NCH = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] reg_addr = '0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [15:0] chan_in = '0;
   logic [15:0] chan_out;
   logic [15:0] fab_in = '0;
   logic [15:0] fab_out;
   logic        irq;

   int n_tests = 0;
   int n_fail  = 0;
   logic [15:0] exp_chan [$];
   logic [15:0] exp_fab  [$];

   always #2 clk = ~clk;

   xproc_event_unit #(.NUM_CH(NCH), .NUM_MEM(4), .FAB_CH(16)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .chan_in(chan_in),
      .chan_out(chan_out), .fab_in(fab_in), .fab_out(fab_out), .irq(irq));

   function automatic logic [11:0] a_task(int n); return 12'(32'h000 + 4 * n); endfunction
   function automatic logic [11:0] a_sub (int n); return 12'(32'h080 + 4 * n); endfunction
   function automatic logic [11:0] a_evt (int n); return 12'(32'h100 + 4 * n); endfunction
   function automatic logic [11:0] a_pub (int n); return 12'(32'h180 + 4 * n); endfunction
   function automatic logic [11:0] a_scfg(int n); return 12'(32'h510 + 4 * n); endfunction
   function automatic logic [11:0] a_rcfg(int n); return 12'(32'h590 + 4 * n); endfunction
   function automatic logic [11:0] a_mem (int n); return 12'(32'h610 + 4 * n); endfunction

   task automatic check(input logic ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      reg_addr = a; reg_we = 1'b0;
      #1;
      check(reg_rdata === exp, tag, reg_rdata, exp);
   endtask

   task automatic pulse_in(input logic [15:0] m);
      @(negedge clk); chan_in = m;
      @(negedge clk); chan_in = '0;
   endtask

   task automatic pulse_fab(input logic [15:0] m);
      @(negedge clk); fab_in = m;
      @(negedge clk); fab_in = '0;
   endtask

   task automatic drained(input string tag);
      @(negedge clk); #1;
      check(exp_chan.size() == 0 && exp_fab.size() == 0, tag,
            32'(exp_chan.size()), 32'(exp_fab.size()));
   endtask

   task automatic chk_irq(input logic exp, input string tag);
      @(negedge clk); #1;
      check(irq === exp, tag, 32'(irq), 32'(exp));
   endtask

   // Monitor: every observed pulse must match the head of its queue
   always @(negedge clk) begin
      if (rst_n && chan_out != '0) begin
         if (exp_chan.size() == 0) check(1'b0, "R2/R9 unexpected chan_out", 32'(chan_out), 0);
         else begin
            logic [15:0] e;
            e = exp_chan.pop_front();
            check(chan_out === e, "R2/R9 chan_out pulse", 32'(chan_out), 32'(e));
         end
      end
      if (rst_n && fab_out != '0) begin
         if (exp_fab.size() == 0) check(1'b0, "R10 unexpected fab_out", 32'(fab_out), 0);
         else begin
            logic [15:0] e;
            e = exp_fab.pop_front();
            check(fab_out === e, "R10 fab_out pulse", 32'(fab_out), 32'(e));
         end
      end
   end

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R12 reset state
      @(negedge clk); #1;
      check(chan_out == '0 && fab_out == '0 && irq == 1'b0, "R12 outputs after reset",
            {chan_out, fab_out}, 0);
      rd(12'h308, 32'h0, "R12 pending after reset");
      rd(a_scfg(0), 32'h0, "R12 send mask after reset");
      rd(a_mem(2), 32'h0, "R12 memory after reset");

      // R3 mask replace
      wr(a_scfg(2), 32'h0000_00F0);
      rd(a_scfg(2), 32'h0000_00F0, "R3 send mask readback");
      wr(a_scfg(2), 32'h0000_0003);
      rd(a_scfg(2), 32'h0000_0003, "R3 send mask replaced");

      // R2 software fire
      exp_chan.push_back(16'h0003);
      wr(a_task(2), 32'h1);
      drained("R2 task 2 pulse");
      wr(a_task(2), 32'h0);
      wr(a_task(5), 32'h1);
      drained("R2 zero write and empty mask give nothing");

      // R1 upper channel of the 16-wide variant
      wr(a_scfg(15), 32'h0000_8001);
      exp_chan.push_back(16'h8001);
      wr(a_task(15), 32'h1);
      drained("R1 task 15 pulse");

      // R4 / R10 receive and publish
      wr(a_pub(3), 32'h8000_0006);
      rd(a_pub(3), 32'h8000_0006, "R8 publish readback");
      wr(a_rcfg(3), 32'h0000_0410);
      exp_fab.push_back(16'h0040);
      pulse_in(16'h0400);
      drained("R10 publish on rise");
      rd(a_evt(3), 32'h1, "R4 event 3 set");
      rd(a_evt(4), 32'h0, "R4 event 4 untouched");
      pulse_in(16'h0010);
      drained("R10 no publish while already set");

      // R5 sticky and clear
      wr(a_evt(3), 32'h1);
      rd(a_evt(3), 32'h1, "R5 write 1 no effect");
      @(negedge clk);
      reg_addr = a_evt(3); reg_wdata = 32'h0; reg_we = 1'b1; chan_in = 16'h0400;
      @(negedge clk);
      reg_we = 1'b0; chan_in = '0;
      rd(a_evt(3), 32'h1, "R5 pulse beats clear");
      wr(a_evt(3), 32'h0);
      rd(a_evt(3), 32'h0, "R5 cleared");

      // R6 interrupt enables
      wr(12'h300, 32'h0000_0009);
      rd(12'h300, 32'h9, "R6 set read");
      rd(12'h304, 32'h9, "R6 clear-address read");
      wr(12'h304, 32'h0000_0001);
      rd(12'h300, 32'h8, "R6 after clear");

      // R7 pending and irq
      chk_irq(1'b0, "R7 irq idle");
      exp_fab.push_back(16'h0040);
      pulse_in(16'h0010);
      rd(12'h308, 32'h8, "R7 pending bit 3");
      chk_irq(1'b1, "R7 irq raised");
      wr(12'h304, 32'h0000_0008);
      rd(12'h308, 32'h0, "R7 pending masked");
      chk_irq(1'b0, "R7 irq dropped");
      rd(a_evt(3), 32'h1, "R7 event kept while masked");

      // R8 publish disable
      wr(a_pub(3), 32'h0);
      rd(a_pub(3), 32'h0, "R8 publish disabled readback");
      wr(a_evt(3), 32'h0);
      pulse_in(16'h0400);
      drained("R10 disabled publish silent");

      // R9 subscribe
      wr(a_sub(4), 32'h8000_0002);
      rd(a_sub(4), 32'h8000_0002, "R8 subscribe readback");
      wr(a_scfg(4), 32'h0000_0100);
      exp_chan.push_back(16'h0100);
      pulse_fab(16'h0004);
      drained("R9 subscribed fire");
      @(negedge clk);
      reg_addr = a_task(4); reg_wdata = 32'h1; reg_we = 1'b1; fab_in = 16'h0004;
      exp_chan.push_back(16'h0100);
      @(negedge clk);
      reg_we = 1'b0; fab_in = '0;
      drained("R9 merged software and subscribed fire");
      wr(a_sub(4), 32'h0);
      rd(a_sub(4), 32'h0, "R8 subscribe disabled readback");
      pulse_fab(16'h0004);
      drained("R9 disabled subscribe silent");

      // R3 receive mask replace
      wr(a_rcfg(5), 32'h0000_0001);
      wr(a_rcfg(5), 32'h0000_0002);
      rd(a_rcfg(5), 32'h2, "R3 receive mask replaced");
      pulse_in(16'h0001);
      rd(a_evt(5), 32'h0, "R3 old receive bit dropped");

      // R11 memory
      wr(a_mem(0), 32'hDEAD_BEEF);
      wr(a_mem(3), 32'h1234_5678);
      rd(a_mem(0), 32'hDEAD_BEEF, "R11 word 0");
      rd(a_mem(3), 32'h1234_5678, "R11 word 3");
      wr(a_mem(4), 32'hFFFF_FFFF);
      rd(a_mem(4), 32'h0, "R11 index 4 reads 0");
      rd(a_mem(0), 32'hDEAD_BEEF, "R11 word 0 kept");
      rd(a_mem(3), 32'h1234_5678, "R11 word 3 kept");

      drained("R2 final scoreboard empty");
      finish_run();
   end
endmodule